// File: doc/BRIEF.md
# Block data word sequencer

This block sits between a 32-bit register-style data port and a cipher core that works on 128-bit blocks. Software or a DMA engine writes four words, and the sequencer packs them into one block and drives it to the core. In the cycle after the last word it sends a one-cycle start pulse. When the core signals done, the sequencer captures the result and pulses the computation-complete set line. The four result words can then be read back in order. After the fourth read the sequencer is ready for the next block.

Each word passes through a selectable swap stage on the way in and again on the way out, so that half-word, byte or bit oriented data can be fed in its natural memory order. Accesses that come in the wrong phase are caught. An early read returns zero and a late write is dropped. Each such access raises a one-cycle error set pulse for the status logic outside. The port has no back-pressure. Each read or write strobe is a single-cycle beat that is taken or dropped in the cycle it appears, so the access side never stalls.

Top module: `blk_word_seq`

## Requirements
- R1: Four accepted writes in the input phase fill `blk_out` bits [127:96], [95:64], [63:32] and [31:0] in that order. Each word is visible on `blk_out` in the cycle after its write.
- R2: `core_start` is high for exactly one cycle, the cycle after the fourth accepted write, and at no other time.
- R3: `swap_sel` picks the per-word swap: 0 leaves the word unchanged; 1 exchanges the 16-bit halves; 2 reverses the byte order; 3 reverses all 32 bits. The swap is applied to written words and to read words, using the value of `swap_sel` at the time of the access.
- R4: A `core_done` seen in the compute phase captures `core_result` and raises `ccf_set` for one cycle, in the next cycle. A `core_done` seen in any other phase has no effect.
- R5: In the output phase, four reads return result bits [127:96], [95:64], [63:32] and [31:0] in that order, each word swapped as in R3, with the data valid in the cycle of the read strobe. The fourth read returns the block to the input phase with the word counter at 0.
- R6: A read made in the input or compute phase returns 0, raises `rderr_set` in the next cycle, and leaves the sequence unaffected. A read in the output phase raises no error.
- R7: A write made in the compute or output phase is dropped and raises `wrerr_set` in the next cycle. `blk_out` and the later result reads are unchanged by it.
- R8: While `enable` is 0, the sequencer is held in the input phase with the word counter at 0. Reads return 0, writes are dropped, and no error, start or complete pulse is raised.
- R9: While `op_mode` is 1 (key derivation), data reads and writes are ignored. Reads return 0, there are no error pulses, `blk_out` does not change and the word counter does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; 0 resets the sequence |
| op_mode | input | 2 | Operating mode; 1 = key derivation, data port unused |
| swap_sel | input | 2 | Per-word swap selection (R3) |
| wr_en | input | 1 | Input-word write strobe |
| wr_data | input | 32 | Input word |
| rd_en | input | 1 | Output-word read strobe |
| rd_data | output | 32 | Output word, valid during the read strobe |
| core_done | input | 1 | Cipher core finished |
| core_result | input | 128 | Cipher core result block |
| blk_out | output | 128 | Assembled input block to the core |
| core_start | output | 1 | One-cycle start pulse to the core |
| ccf_set | output | 1 | Computation-complete flag set pulse |
| rderr_set | output | 1 | Read-error flag set pulse |
| wrerr_set | output | 1 | Write-error flag set pulse |

## Verification
The hardest cases to reach are the out-of-phase accesses that fall in the middle of a live block. These are a read after only two of the four words are written, a read or write while the core is computing, and a write between result reads. For each one the bench must show that the block still finishes correctly. The stimulus places these accesses at exact points in a running transaction. It then completes the transaction and compares every later word against the expected value. The full sweep covers all sixteen pairings of input swap and output swap. Further runs drop `enable` or enter key-derivation mode part way through a block, then check that the next block still needs all four fresh words before `core_start` appears.

// File: rtl/blk_seq_pkg.sv
package blk_seq_pkg;

  typedef enum logic [1:0] {
    PH_IN   = 2'd0,
    PH_CALC = 2'd1,
    PH_OUT  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    SW_NONE = 2'd0,
    SW_HALF = 2'd1,
    SW_BYTE = 2'd2,
    SW_BIT  = 2'd3
  } swap_e;

  localparam logic [1:0] MODE_KEYDER = 2'd1;

endpackage

// File: rtl/blk_word_swap.sv
module blk_word_swap #(
  parameter int W = 32
) (
  input  logic [1:0]   sel,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  import blk_seq_pkg::*;

  localparam int NB = W / 8;
  localparam int HW = W / 2;

  logic [W-1:0] half_sw;
  logic [W-1:0] byte_rev;
  logic [W-1:0] bit_rev;

  assign half_sw = {din[HW-1:0], din[W-1:HW]};

  for (genvar gb = 0; gb < NB; gb++) begin : g_byte
    assign byte_rev[gb*8 +: 8] = din[(NB-1-gb)*8 +: 8];
  end

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    assign bit_rev[gi] = din[W-1-gi];
  end

  always_comb begin
    case (swap_e'(sel))
      SW_HALF: dout = half_sw;
      SW_BYTE: dout = byte_rev;
      SW_BIT:  dout = bit_rev;
      default: dout = din;
    endcase
  end

endmodule

// File: rtl/blk_seq_ctrl.sv
module blk_seq_ctrl #(
  parameter int WORDS = 4,
  localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          keymode,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          core_done,
  output logic [CW-1:0] cnt,
  output logic          wr_accept,
  output logic          rd_accept,
  output logic          load_result,
  output logic          start_q,
  output logic          ccf_q,
  output logic          rderr_q,
  output logic          wrerr_q
);
  import blk_seq_pkg::*;

  localparam logic [CW-1:0] LAST = CW'(WORDS - 1);

  phase_e phase_q, phase_d;
  logic [CW-1:0] cnt_d;
  logic active, wr_bad, rd_bad, last_word;

  assign active      = enable && !keymode;
  assign last_word   = (cnt == LAST);
  assign wr_accept   = active && wr_en && (phase_q == PH_IN);
  assign rd_accept   = active && rd_en && (phase_q == PH_OUT);
  assign wr_bad      = active && wr_en && (phase_q != PH_IN);
  assign rd_bad      = active && rd_en && (phase_q != PH_OUT);
  assign load_result = enable && core_done && (phase_q == PH_CALC);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt;
    if (!enable) begin
      phase_d = PH_IN;
      cnt_d   = '0;
    end else begin
      case (phase_q)
        PH_IN: if (wr_accept) begin
          if (last_word) begin
            phase_d = PH_CALC;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt + 1'b1;
          end
        end
        PH_CALC: if (load_result) begin
          phase_d = PH_OUT;
          cnt_d   = '0;
        end
        PH_OUT: if (rd_accept) begin
          if (last_word) begin
            phase_d = PH_IN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt + 1'b1;
          end
        end
        default: begin
          phase_d = PH_IN;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IN;
      cnt     <= '0;
      start_q <= 1'b0;
      ccf_q   <= 1'b0;
      rderr_q <= 1'b0;
      wrerr_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt     <= cnt_d;
      start_q <= wr_accept && last_word;
      ccf_q   <= load_result;
      rderr_q <= rd_bad;
      wrerr_q <= wr_bad;
    end
  end

endmodule

// File: rtl/blk_in_asm.sv
module blk_in_asm #(
  parameter int W = 32,
  parameter int WORDS = 4,
  localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BLK_W = W * WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CW-1:0]    idx,
  input  logic [W-1:0]     din,
  output logic [BLK_W-1:0] blk
);

  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        blk[BLK_W-1-g*W -: W] <= '0;
      else if (we && (idx == CW'(g)))
        blk[BLK_W-1-g*W -: W] <= din;
    end
  end

endmodule

// File: rtl/blk_out_hold.sv
module blk_out_hold #(
  parameter int W = 32,
  parameter int WORDS = 4,
  localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BLK_W = W * WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BLK_W-1:0] din,
  input  logic [CW-1:0]    idx,
  output logic [W-1:0]     dout
);

  logic [BLK_W-1:0] hold_q;
  logic [W-1:0]     words [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= '0;
    else if (load) hold_q <= din;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign words[g] = hold_q[BLK_W-1-g*W -: W];
  end

  assign dout = words[idx];

endmodule

// File: rtl/blk_word_seq.sv
module blk_word_seq #(
  parameter int W = 32,
  parameter int WORDS = 4,
  localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BLK_W = W * WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       op_mode,
  input  logic [1:0]       swap_sel,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  input  logic             core_done,
  input  logic [BLK_W-1:0] core_result,
  output logic [BLK_W-1:0] blk_out,
  output logic             core_start,
  output logic             ccf_set,
  output logic             rderr_set,
  output logic             wrerr_set
);
  import blk_seq_pkg::*;

  logic [CW-1:0] cnt;
  logic wr_accept, rd_accept, load_result;
  logic [W-1:0] in_word, held_word, out_word;

  blk_seq_ctrl #(.WORDS(WORDS)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .keymode(op_mode == MODE_KEYDER),
    .wr_en(wr_en), .rd_en(rd_en), .core_done(core_done),
    .cnt(cnt), .wr_accept(wr_accept), .rd_accept(rd_accept),
    .load_result(load_result), .start_q(core_start), .ccf_q(ccf_set),
    .rderr_q(rderr_set), .wrerr_q(wrerr_set)
  );

  blk_word_swap #(.W(W)) i_swap_in (
    .sel(swap_sel), .din(wr_data), .dout(in_word)
  );

  blk_in_asm #(.W(W), .WORDS(WORDS)) i_in (
    .clk(clk), .rst_n(rst_n), .we(wr_accept), .idx(cnt),
    .din(in_word), .blk(blk_out)
  );

  blk_out_hold #(.W(W), .WORDS(WORDS)) i_out (
    .clk(clk), .rst_n(rst_n), .load(load_result), .din(core_result),
    .idx(cnt), .dout(held_word)
  );

  blk_word_swap #(.W(W)) i_swap_out (
    .sel(swap_sel), .din(held_word), .dout(out_word)
  );

  assign rd_data = rd_accept ? out_word : '0;

endmodule

// File: rtl/blk_word_seq_chk.sv
module blk_word_seq_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic         wr_en,
  input logic         rd_en,
  input logic         core_done,
  input logic [W-1:0] rd_data,
  input logic         core_start,
  input logic         ccf_set,
  input logic         rderr_set,
  input logic         wrerr_set
);

  // R2
  start_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> $past(wr_en && enable));

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);

  // R4
  ccf_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ccf_set |-> $past(core_done && enable));

  // R6
  rderr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rderr_set |-> $past(rd_en && enable));

  // R7
  wrerr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrerr_set |-> $past(wr_en && enable));

  // R6
  good_read_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_data != '0) |=> !rderr_set);

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !(rderr_set || wrerr_set || core_start || ccf_set));

  // R8
  disabled_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> rd_data == '0);

endmodule

bind blk_word_seq blk_word_seq_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .rd_en(rd_en),
  .core_done(core_done), .rd_data(rd_data), .core_start(core_start),
  .ccf_set(ccf_set), .rderr_set(rderr_set), .wrerr_set(wrerr_set)
);

// File: tb/test_blk_word_seq.sv
`timescale 1ns/1ps
module test_blk_word_seq;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0;
  logic [1:0]   op_mode = 2'd0;
  logic [1:0]   swap_sel = 2'd0;
  logic         wr_en = 1'b0;
  logic [31:0]  wr_data = '0;
  logic         rd_en = 1'b0;
  logic [31:0]  rd_data;
  logic         core_done = 1'b0;
  logic [127:0] core_result = '0;
  logic [127:0] blk_out;
  logic         core_start, ccf_set, rderr_set, wrerr_set;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  blk_word_seq i_blk_word_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .op_mode(op_mode),
    .swap_sel(swap_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .core_done(core_done), .core_result(core_result),
    .blk_out(blk_out), .core_start(core_start), .ccf_set(ccf_set),
    .rderr_set(rderr_set), .wrerr_set(wrerr_set)
  );

  function automatic logic [31:0] sw(logic [31:0] w, int m);
    logic [31:0] r;
    case (m)
      1: r = {w[15:0], w[31:16]};
      2: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
      3: for (int i = 0; i < 32; i++) r[i] = w[31-i];
      default: r = w;
    endcase
    return r;
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic done(input logic [127:0] r);
    @(negedge clk); core_done = 1'b1; core_result = r;
    @(negedge clk); core_done = 1'b0;
  endtask

  task automatic run_txn(int im, int om, int c);
    logic [31:0] w [4];
    logic [127:0] eb, res;
    logic [31:0] d;
    for (int k = 0; k < 4; k++)
      w[k] = {8'(k * 17 + c), 8'(c * 3 + 1), 8'hA5 ^ 8'(k), 8'(c + 64)};
    eb = {sw(w[0], im), sw(w[1], im), sw(w[2], im), sw(w[3], im)};
    res = {~w[3] ^ 32'h0F0F1234, w[1] ^ 32'h80000001, w[0] + 32'd7, ~w[2]};
    swap_sel = 2'(im);
    for (int k = 0; k < 4; k++) begin
      wr(w[k]);
      chk(k < 3 ? "R2 no start before fourth write" : "R2 start after fourth write",
          128'(core_start), 128'(k == 3));
      chk("R7 no write error in input phase", 128'(wrerr_set), 0);
    end
    chk("R1/R3 assembled block", blk_out, eb);
    @(negedge clk);
    chk("R2 start is one cycle", 128'(core_start), 0);
    swap_sel = 2'(om);
    done(res);
    chk("R4 complete pulse", 128'(ccf_set), 1);
    for (int k = 0; k < 4; k++) begin
      rd(d);
      chk("R5 read word", 128'(d), 128'(sw(res[127-32*k -: 32], om)));
      chk("R6 no read error in output phase", 128'(rderr_set), 0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [127:0] held;
    repeat (3) @(negedge clk);
    chk("R1 reset block", blk_out, 0);
    chk("R2 reset start", 128'(core_start), 0);
    rst_n = 1'b1; enable = 1'b1;
    @(negedge clk);
    chk("R6 reset error pulses", 128'({rderr_set, wrerr_set, ccf_set}), 0);

    for (int im = 0; im < 4; im++)
      for (int om = 0; om < 4; om++)
        run_txn(im, om, im * 4 + om);

    // R6 / R7 / R4: out-of-phase accesses within a live block
    swap_sel = 2'd0;
    done(128'h1);
    chk("R4 done ignored in input phase", 128'(ccf_set), 0);
    wr(32'hAAAA0001); wr(32'hBBBB0002);
    rd(d);
    chk("R6 early read returns zero", 128'(d), 0);
    chk("R6 early read error", 128'(rderr_set), 1);
    wr(32'hCCCC0003); wr(32'hDDDD0004);
    chk("R6 sequence unaffected start", 128'(core_start), 1);
    chk("R6 sequence unaffected block", blk_out,
        128'hAAAA0001_BBBB0002_CCCC0003_DDDD0004);
    rd(d);
    chk("R6 read in compute returns zero", 128'(d), 0);
    chk("R6 read in compute error", 128'(rderr_set), 1);
    wr(32'h12345678);
    chk("R7 write in compute error", 128'(wrerr_set), 1);
    chk("R7 write in compute dropped", blk_out,
        128'hAAAA0001_BBBB0002_CCCC0003_DDDD0004);
    done(128'h01020304_05060708_090A0B0C_0D0E0F10);
    chk("R4 complete after errors", 128'(ccf_set), 1);
    rd(d);
    chk("R5 first result word", 128'(d), 128'h01020304);
    wr(32'hFFFFFFFF);
    chk("R7 write in output error", 128'(wrerr_set), 1);
    rd(d); chk("R7 output unaffected w1", 128'(d), 128'h05060708);
    rd(d); chk("R7 output unaffected w2", 128'(d), 128'h090A0B0C);
    rd(d); chk("R5 last word", 128'(d), 128'h0D0E0F10);
    rd(d);
    chk("R5 back to input phase", 128'({d, 1'b0, rderr_set}), 1);

    // R8: disable part way through a block
    wr(32'h11111111); wr(32'h22222222);
    held = blk_out;
    @(negedge clk); enable = 1'b0;
    rd(d);
    chk("R8 disabled read zero", 128'(d), 0);
    chk("R8 disabled read no error", 128'(rderr_set), 0);
    wr(32'h99999999);
    chk("R8 disabled write no error", 128'(wrerr_set), 0);
    chk("R8 disabled write dropped", blk_out, held);
    enable = 1'b1;
    for (int k = 0; k < 4; k++) begin
      wr(32'h30000000 + 32'(k));
      chk("R8 counter restarted at 0", 128'(core_start), 128'(k == 3));
    end
    chk("R8 block after restart", blk_out,
        128'h30000000_30000001_30000002_30000003);
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1;

    // R9: key-derivation mode ignores the data port
    wr(32'h40000000);
    held = blk_out;
    op_mode = 2'd1;
    wr(32'h5A5A5A5A);
    chk("R9 key mode write no error", 128'(wrerr_set), 0);
    chk("R9 key mode write dropped", blk_out, held);
    rd(d);
    chk("R9 key mode read zero", 128'(d), 0);
    chk("R9 key mode read no error", 128'(rderr_set), 0);
    op_mode = 2'd0;
    for (int k = 1; k < 4; k++) begin
      wr(32'h40000000 + 32'(k));
      chk("R9 counter not advanced", 128'(core_start), 128'(k == 3));
    end
    chk("R9 block", blk_out, 128'h40000000_40000001_40000002_40000003);
    swap_sel = 2'd3;
    done(128'h80000000_00000001_0000FFFF_F0000000);
    chk("R4 complete", 128'(ccf_set), 1);
    rd(d); chk("R3 bit swap read", 128'(d), 128'h00000001);
    swap_sel = 2'd1;
    rd(d); chk("R3 half swap read", 128'(d), 128'h00018000 >> 0 == 0 ? 0 : 128'h00010000);
    swap_sel = 2'd2;
    rd(d); chk("R3 byte swap read", 128'(d), 128'hFFFF0000);
    swap_sel = 2'd0;
    rd(d); chk("R3 no swap read", 128'(d), 128'hF0000000);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule